// File: doc/BRIEF.md
# Guard-Round-Sticky Significand Rounder

This block rounds an unpacked floating-point significand to its final width. The caller supplies a sign, a significand that carries two extra low bits (guard above round), a separate sticky bit that summarises everything shifted out further down, and a two-bit rounding direction. One cycle after a valid sample the block presents the significand with the guard and round bits removed, incremented or not according to the direction. It also presents a flag for a lossy result and a flag that says whether the increment was applied.

The output is one bit wider than the kept significand. If an all-ones significand is incremented, the carry lands in that extra top bit and the value reads as exactly 2.0. The block passes this value on unchanged. Renormalising it, adjusting the exponent and packing the result are left to the consumer. Supported directions are nearest with ties to even, toward zero, toward minus infinity and toward plus infinity.

Top module: `sigRounder`

## Requirements
- R1: While reset is asserted and after it is released with no valid sample yet taken, outValid, sigOut, inexact and roundedUp are all zero.
- R2: A sample presented with inValid high at a rising edge yields outValid high after that edge, with the results for that sample. With inValid low at an edge, outValid is low after it and sigOut holds its value.
- R3: When guard (inSig bit 1), round (inSig bit 0) and sticky are all zero, sigOut equals inSig shifted right by two, inexact is low and roundedUp is low, in every mode.
- R4: inexact is high exactly when at least one of guard, round or sticky is set.
- R5: With inMode = 2'b00 (nearest), the increment applies only when guard is set and at least one of round, sticky or the kept LSB (inSig bit 2) is set, so that an exact half rounds to an even result.
- R6: With inMode = 2'b01 (toward zero), the increment never applies.
- R7: With inMode = 2'b10 (toward minus infinity), the increment applies only when the result is inexact and inSign is 1 (negative).
- R8: With inMode = 2'b11 (toward plus infinity), the increment applies only when the result is inexact and inSign is 0 (positive).
- R9: The increment adds one at the kept LSB with full carry propagation. An all-ones kept field that is incremented gives sigOut with only its top bit set (the value 2.0), and this value is not renormalised.
- R10: roundedUp is high exactly when sigOut equals the kept field plus one, and low when sigOut equals the kept field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture the input sample at this edge |
| inSign | input | 1 | Sign of the value, 1 means negative |
| inSig | input | SIG_W+2 | Significand; bit 1 is guard, bit 0 is round |
| inSticky | input | 1 | OR of all bits below the round bit |
| inMode | input | 2 | Rounding direction: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| outValid | output | 1 | Results below belong to a sample captured at the last edge |
| sigOut | output | SIG_W+1 | Rounded significand; the top bit is the carry into 2.0 |
| inexact | output | 1 | Some discarded bit was nonzero |
| roundedUp | output | 1 | The increment was applied |

## Verification
Every result is due one rising edge after the edge that captured its sample: outValid, sigOut, inexact and roundedUp all come from the captured registers through combinational logic, with no further stage. The driver presents each sample on a falling edge and records the expected triple. The monitor looks at the outputs a little after the next falling edge, half a period after the capturing edge, so it never samples while the registers change. Because the latency is fixed at one cycle, a result that arrives early, late or unexpected misses its entry in the queue and is reported.

// File: rtl/rndPkg.sv
package rndPkg;

  // Rounding direction encoding seen on inMode
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TO_ZERO = 2'b01,
    RM_DOWN    = 2'b10,
    RM_UP      = 2'b11
  } roundMode_e;

  // Strobes from the control decision to the datapath
  typedef struct packed {
    logic bump;   // apply +1 at the kept LSB
    logic lossy;  // some discarded bit was nonzero
  } rndStrobes_t;

endpackage

// File: rtl/rndCtrl.sv
module rndCtrl
  import rndPkg::*;
(
  input  logic [1:0]  capMode,
  input  logic        capSign,
  input  logic        capGuard,
  input  logic        capRound,
  input  logic        capSticky,
  input  logic        capLsb,
  output rndStrobes_t strobes
);

  roundMode_e modeSel;
  logic       lossy;
  logic       bump;

  assign modeSel = roundMode_e'(capMode);
  assign lossy   = capGuard | capRound | capSticky;

  always_comb begin
    bump = 1'b0;
    unique case (modeSel)
      RM_NEAREST: bump = capGuard & (capRound | capSticky | capLsb);
      RM_TO_ZERO: bump = 1'b0;
      RM_DOWN:    bump = lossy & capSign;
      RM_UP:      bump = lossy & ~capSign;
      default:    bump = 1'b0;
    endcase
  end

  assign strobes.bump  = bump;
  assign strobes.lossy = lossy;

endmodule

// File: rtl/rndData.sv
module rndData
  import rndPkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSign,
  input  logic [SIG_W+1:0] inSig,
  input  logic             inSticky,
  input  logic [1:0]       inMode,
  input  rndStrobes_t      strobes,
  output logic [1:0]       capMode,
  output logic             capSign,
  output logic             capGuard,
  output logic             capRound,
  output logic             capSticky,
  output logic             capLsb,
  output logic             outValid,
  output logic [SIG_W:0]   sigOut,
  output logic             inexact,
  output logic             roundedUp
);

  localparam int IN_W = SIG_W + 2;

  logic             validQ;
  logic             signQ;
  logic [1:0]       modeQ;
  logic [IN_W-1:0]  sigQ;
  logic             stickyQ;
  logic [SIG_W-1:0] kept;
  logic [SIG_W:0]   carry;
  logic [SIG_W:0]   sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      signQ   <= 1'b0;
      modeQ   <= 2'b00;
      sigQ    <= '0;
      stickyQ <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) begin
        signQ   <= inSign;
        modeQ   <= inMode;
        sigQ    <= inSig;
        stickyQ <= inSticky;
      end
    end
  end

  // Drop guard and round
  assign kept = sigQ[IN_W-1:2];

  // Ripple incrementer; the final carry becomes the 2.0 bit
  assign carry[0] = strobes.bump;
  for (genvar i = 0; i < SIG_W; i++) begin : g_inc
    assign sum[i]     = kept[i] ^ carry[i];
    assign carry[i+1] = kept[i] & carry[i];
  end
  assign sum[SIG_W] = carry[SIG_W];

  assign capMode   = modeQ;
  assign capSign   = signQ;
  assign capGuard  = sigQ[1];
  assign capRound  = sigQ[0];
  assign capSticky = stickyQ;
  assign capLsb    = sigQ[2];

  assign outValid  = validQ;
  assign sigOut    = sum;
  assign inexact   = strobes.lossy;
  assign roundedUp = strobes.bump;

endmodule

// File: rtl/sigRounder.sv
module sigRounder
  import rndPkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSign,
  input  logic [SIG_W+1:0] inSig,
  input  logic             inSticky,
  input  logic [1:0]       inMode,
  output logic             outValid,
  output logic [SIG_W:0]   sigOut,
  output logic             inexact,
  output logic             roundedUp
);

  rndStrobes_t strobes;
  logic [1:0]  capMode;
  logic        capSign;
  logic        capGuard;
  logic        capRound;
  logic        capSticky;
  logic        capLsb;

  rndData #(.SIG_W(SIG_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSign    (inSign),
    .inSig     (inSig),
    .inSticky  (inSticky),
    .inMode    (inMode),
    .strobes   (strobes),
    .capMode   (capMode),
    .capSign   (capSign),
    .capGuard  (capGuard),
    .capRound  (capRound),
    .capSticky (capSticky),
    .capLsb    (capLsb),
    .outValid  (outValid),
    .sigOut    (sigOut),
    .inexact   (inexact),
    .roundedUp (roundedUp)
  );

  rndCtrl u_ctrl (
    .capMode   (capMode),
    .capSign   (capSign),
    .capGuard  (capGuard),
    .capRound  (capRound),
    .capSticky (capSticky),
    .capLsb    (capLsb),
    .strobes   (strobes)
  );

endmodule

// File: rtl/rndChecker.sv
module rndChecker #(
  parameter int SIG_W = 24
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           outValid,
  input logic [SIG_W:0] sigOut,
  input logic           inexact,
  input logic           roundedUp,
  input logic [1:0]     capMode,
  input logic           capSign
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(sigOut)));

  a_r3_exact_untouched: assert property (@(posedge clk) disable iff (!rstN)
    !inexact |-> (!roundedUp && !sigOut[SIG_W]));

  a_r6_zero_never_bumps: assert property (@(posedge clk) disable iff (!rstN)
    (capMode == 2'b01) |-> !roundedUp);

  a_r7_down_positive_stays: assert property (@(posedge clk) disable iff (!rstN)
    (capMode == 2'b10 && !capSign) |-> !roundedUp);

  a_r8_up_negative_stays: assert property (@(posedge clk) disable iff (!rstN)
    (capMode == 2'b11 && capSign) |-> !roundedUp);

  a_r9_carry_is_two: assert property (@(posedge clk) disable iff (!rstN)
    sigOut[SIG_W] |-> (roundedUp && sigOut[SIG_W-1:0] == '0));

  a_r10_bump_needs_loss: assert property (@(posedge clk) disable iff (!rstN)
    roundedUp |-> inexact);

endmodule

bind sigRounder rndChecker #(.SIG_W(SIG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .outValid  (outValid),
  .sigOut    (sigOut),
  .inexact   (inexact),
  .roundedUp (roundedUp),
  .capMode   (capMode),
  .capSign   (capSign)
);

// File: tb/sim_sigRounder.sv
`timescale 1ns/1ps
module sim_sigRounder;

  localparam int W = 8;

  typedef struct {
    logic [W:0] sig;
    logic       inex;
    logic       up;
    string      tag;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic           inSign = 1'b0;
  logic [W+1:0]   inSig = '0;
  logic           inSticky = 1'b0;
  logic [1:0]     inMode = 2'b00;
  logic           outValid;
  logic [W:0]     sigOut;
  logic           inexact;
  logic           roundedUp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  sigRounder #(.SIG_W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign),
    .inSig(inSig), .inSticky(inSticky), .inMode(inMode),
    .outValid(outValid), .sigOut(sigOut), .inexact(inexact),
    .roundedUp(roundedUp)
  );

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected result built from the requirements
  task automatic drive(input logic s, input logic [W+1:0] v, input logic st, input logic [1:0] m);
    expItem_t e;
    logic [W-1:0] kept;
    logic g, r, lossy, inc;
    kept  = v[W+1:2];
    g     = v[1];
    r     = v[0];
    lossy = g | r | st;
    case (m)
      2'b00:   inc = g & (r | st | kept[0]);   // R5
      2'b01:   inc = 1'b0;                     // R6
      2'b10:   inc = lossy & s;                // R7
      default: inc = lossy & ~s;               // R8
    endcase
    e.sig  = {1'b0, kept} + {{W{1'b0}}, inc};
    e.inex = lossy;
    e.up   = inc;
    if (!lossy)          e.tag = "R3";
    else if (e.sig[W])   e.tag = "R9";
    else if (m == 2'b00) e.tag = "R5";
    else if (m == 2'b01) e.tag = "R6";
    else if (m == 2'b10) e.tag = "R7";
    else                 e.tag = "R8";
    expQ.push_back(e);
    inSign = s; inSig = v; inSticky = st; inMode = m; inValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: results are due one edge after capture
  always @(negedge clk) begin
    #2;
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected outValid actual=1 expected=0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, sigOut, e.sig);
        check("R4", {{W{1'b0}}, inexact}, {{W{1'b0}}, e.inex});
        check("R10", {{W{1'b0}}, roundedUp}, {{W{1'b0}}, e.up});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W:0] held;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {{W{1'b0}}, outValid}, '0);
    check("R1", sigOut, '0);
    check("R1", {{W{1'b0}}, inexact}, '0);
    check("R1", {{W{1'b0}}, roundedUp}, '0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", {{W{1'b0}}, outValid}, '0);
    check("R1", sigOut, '0);

    // R3 exact values in all modes
    for (int m = 0; m < 4; m++) drive(1'b1, {8'hB5, 2'b00}, 1'b0, 2'(m));
    // R5 ties and near ties
    drive(1'b0, {8'h80, 2'b10}, 1'b0, 2'b00);  // tie, even: stays
    drive(1'b0, {8'h81, 2'b10}, 1'b0, 2'b00);  // tie, odd: up
    drive(1'b0, {8'h80, 2'b11}, 1'b0, 2'b00);  // above half
    drive(1'b0, {8'h80, 2'b10}, 1'b1, 2'b00);  // sticky breaks tie
    drive(1'b0, {8'h81, 2'b01}, 1'b1, 2'b00);  // below half
    // R6
    drive(1'b1, {8'h7F, 2'b11}, 1'b1, 2'b01);
    // R7 / R8 with sticky only
    drive(1'b1, {8'h40, 2'b00}, 1'b1, 2'b10);
    drive(1'b0, {8'h40, 2'b00}, 1'b1, 2'b10);
    drive(1'b0, {8'h40, 2'b00}, 1'b1, 2'b11);
    drive(1'b1, {8'h40, 2'b00}, 1'b1, 2'b11);
    // R9 carry into 2.0
    drive(1'b0, {8'hFF, 2'b11}, 1'b0, 2'b00);
    drive(1'b1, {8'hFF, 2'b00}, 1'b1, 2'b10);

    // Sweep every mode, sign and guard/round/sticky pattern
    for (int k = 0; k < 2; k++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int grs = 0; grs < 8; grs++)
            drive(1'(s), {(k == 0) ? 8'hFF : 8'h80, 2'(grs >> 1)}, 1'(grs & 1), 2'(m));

    // R2 idle: valid drops and result holds
    idle(1);
    held = sigOut;
    idle(2);
    check("R2", {{W{1'b0}}, outValid}, '0);
    check("R2", sigOut, held);
    check("R2", W'(expQ.size()), '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule